// File: doc/BRIEF.md
# Oversampled SPI Register-Read Slave

This block is a serial-peripheral slave that lives entirely in a fast system clock domain. The serial clock, serial data-in and active-low select arrive as asynchronous pins. The serial clock passes through a two-flop synchroniser and then a three-sample history. A rising or falling serial edge is recognised only when two steady samples follow the opposite level, so a one-sample spike or dropout is thrown away as bounce. Data-in and select are delayed through a matching pipeline, so each captured bit is the pin value sampled at the same instant as the first steady sample of the clock edge.

Each access is a fixed 24-clock frame in serial mode 0, most significant bit first. The master sends a device-address byte and then a register-address byte. During the following eight serial clocks the slave returns the addressed byte. The first returned bit appears on data-out a few system clocks after the last address bit is captured, well before the next serial falling edge. A small register file is loaded from the chip side through a parallel write port. A frame with the wrong device address leaves data-out low. Raising select at any point abandons the frame.

Top module: `spi_regread_slave`

## Requirements
- R1: The serial clock is synchronised through two flops and kept in a 3-sample history (oldest to newest). A rising edge is accepted only on the pattern 0,1,1 while the filtered level is low. A falling edge is accepted only on 1,0,0 while the filtered level is high. Two accepted edges are always at least two system clocks apart.
- R2: A serial-clock pulse or dropout lasting one system-clock sample (history 0,1,0 or 1,0,1) creates no edge, and a frame containing such glitches returns the same data as a clean frame.
- R3: Data-in and select go through a synchroniser and delay of the same depth as the clock path. Data-in is captured on each accepted rising edge and shifted in most significant bit first.
- R4: A frame is 8 device-address bits, then 8 register-address bits, then 8 readback clocks, in mode 0. It works with each serial clock level held for 8 system clocks, which is a system clock 16 times the serial rate. The bit counter never exceeds 8.
- R5: The first readback bit (bit 7 of the register) is on data-out one system clock after the last register-address bit is captured. Each later bit changes only on an accepted falling edge.
- R6: If the device-address byte differs from the DEV_ADDR parameter (default 0xA5), data-out stays low for the rest of the frame.
- R7: Raising select at any point returns the slave to idle with the bit counter cleared on the next cycle. The next frame then works normally.
- R8: After reset, data-out is 0. Data-out is also 0 during both address bytes and after the eighth readback bit.
- R9: When the write enable is high and the write address is below NREG, the write data is stored at that address and returned by later reads. A register address of NREG or above reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock pin (asynchronous) |
| mosi_i | input | 1 | Serial data from master (asynchronous) |
| csn_i | input | 1 | Active-low select (asynchronous) |
| miso_o | output | 1 | Serial data to master |
| wr_en | input | 1 | Register-file write strobe |
| wr_addr | input | AW | Register-file write index |
| wr_data | input | BW | Register-file write value |

## Verification
Every cycle, the assertions check the following:
- accepted edges never come in adjacent cycles and never both at once;
- the bit counter stays within bound;
- a raised select always leaves the frame idle on the next cycle;
- the first readback bit equals the addressed register's top bit one cycle after the last address capture;
- data-out only moves on a filtered falling edge during readback;
- register writes land where addressed.

Only the bench's frames can show the following end-to-end results:
- the correct byte comes back for various addresses;
- injected one-sample glitches leave the result unchanged;
- mismatched device addresses and out-of-range registers give zeros;
- a frame abandoned partway does not corrupt the next one.

// File: rtl/spi_rr_pkg.sv
package spi_rr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_REG,
    ST_READ,
    ST_PARK
  } frame_st_t;

  // history is {oldest, middle, newest}
  function automatic logic hist_rise(input logic [2:0] h);
    return (h == 3'b011);
  endfunction

  function automatic logic hist_fall(input logic [2:0] h);
    return (h == 3'b100);
  endfunction

  function automatic logic hist_bounce(input logic [2:0] h);
    return (h == 3'b101) || (h == 3'b010);
  endfunction

endpackage

// File: rtl/spi_clk_filter.sv
module spi_clk_filter #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_pin,
  output logic rise_o,
  output logic fall_o
);
  import spi_rr_pkg::*;

  logic [SYNC-1:0] sync_q;
  logic [2:0]      hist_q;
  logic            lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= '0;
      lvl_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], sclk_pin};
      hist_q <= {hist_q[1:0], sync_q[SYNC-1]};
      if (rise_o)      lvl_q <= 1'b1;
      else if (fall_o) lvl_q <= 1'b0;
    end
  end

  assign rise_o = hist_rise(hist_q) && !lvl_q;
  assign fall_o = hist_fall(hist_q) &&  lvl_q;

  // R1: accepted edges are separated by at least two cycles
  a_r1_edge_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o || fall_o) |=> !(rise_o || fall_o));

  // R2: never both edges together
  a_r2_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_o, fall_o}));

  // R2: a bounce history flips no level on the next cycle
  a_r2_bounce_holds_level: assert property (@(posedge clk) disable iff (!rst_n)
    hist_bounce(hist_q) |=> $stable(lvl_q));

endmodule

// File: rtl/spi_in_align.sv
module spi_in_align #(
  parameter int             W       = 2,
  parameter int             DEPTH   = 4,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[DEPTH-1];
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank #(
  parameter int BW   = 8,
  parameter int NREG = 16,
  parameter int AW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [BW-1:0] wr_data,
  input  logic [BW-1:0] rd_idx,
  output logic [BW-1:0] rd_data
);
  logic [BW-1:0] mem_q [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
    end else if (wr_en && (int'(wr_addr) < NREG)) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_idx) < NREG) rd_data = mem_q[rd_idx[AW-1:0]];
  end

  // R9: an in-range write is visible on the next cycle
  a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (int'(wr_addr) < NREG)) |=> (mem_q[$past(wr_addr)] == $past(wr_data)));

endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl #(
  parameter int            BW       = 8,
  parameter logic [BW-1:0] DEV_ADDR = 'hA5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          mosi_i,
  input  logic          csn_i,
  output logic [BW-1:0] rd_idx_o,
  input  logic [BW-1:0] rd_data_i,
  output logic          miso_o
);
  import spi_rr_pkg::*;

  localparam int CW = $clog2(BW + 1);
  localparam logic [CW-1:0] LAST = CW'(BW - 1);
  localparam logic [CW-1:0] FULL = CW'(BW);

  frame_st_t     st_q;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] in_sr_q;
  logic [BW-1:0] out_sr_q;
  logic [BW-1:0] in_next;
  logic          last_bit;

  assign in_next  = {in_sr_q[BW-2:0], mosi_i};
  assign last_bit = (cnt_q == LAST);
  assign rd_idx_o = in_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      in_sr_q  <= '0;
      out_sr_q <= '0;
    end else if (csn_i) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      in_sr_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_DEV: begin
          st_q <= ST_DEV;
          if (rise_i) begin
            in_sr_q <= in_next;
            if (last_bit) begin
              cnt_q <= '0;
              st_q  <= (in_next == DEV_ADDR) ? ST_REG : ST_PARK;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_REG: begin
          if (rise_i) begin
            in_sr_q <= in_next;
            if (last_bit) begin
              cnt_q    <= '0;
              st_q     <= ST_READ;
              out_sr_q <= rd_data_i;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_READ: begin
          if (rise_i && cnt_q < FULL) begin
            cnt_q <= cnt_q + 1'b1;
          end else if (fall_i && cnt_q != '0) begin
            if (cnt_q == FULL) st_q <= ST_PARK;
            else               out_sr_q <= {out_sr_q[BW-2:0], 1'b0};
          end
        end
        default: st_q <= ST_PARK;
      endcase
    end
  end

  always_comb begin
    miso_o = 1'b0;
    if (st_q == ST_READ) miso_o = out_sr_q[BW-1];
  end

  // R4: counter bound
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);

  // R7: select high abandons the frame
  a_r7_abort: assert property (@(posedge clk) disable iff (!rst_n)
    csn_i |=> (st_q == ST_IDLE && cnt_q == '0));

  // R5: first readback bit ready one cycle after last address capture
  a_r5_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (!csn_i && st_q == ST_REG && rise_i && last_bit)
      |=> (st_q == ST_READ && miso_o == $past(rd_data_i[BW-1])));

  // R5: readback bits move only on a filtered falling edge
  a_r5_shift_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_READ && !fall_i && !csn_i) |=> $stable(miso_o));

endmodule

// File: rtl/spi_regread_slave.sv
module spi_regread_slave #(
  parameter int            BW       = 8,
  parameter int            NREG     = 16,
  parameter int            AW       = $clog2(NREG),
  parameter int            SYNC     = 2,
  parameter logic [BW-1:0] DEV_ADDR = 'hA5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_i,
  input  logic          mosi_i,
  input  logic          csn_i,
  output logic          miso_o,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [BW-1:0] wr_data
);
  // clock path reaches the middle history slot after SYNC + 2 flops
  localparam int ALIGN = SYNC + 2;

  logic          sck_rise;
  logic          sck_fall;
  logic [1:0]    pins_al;
  logic [BW-1:0] rd_idx;
  logic [BW-1:0] rd_data;

  spi_clk_filter #(.SYNC(SYNC)) u_filt (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_pin (sclk_i),
    .rise_o   (sck_rise),
    .fall_o   (sck_fall)
  );

  spi_in_align #(.W(2), .DEPTH(ALIGN), .RST_VAL(2'b10)) u_align (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({csn_i, mosi_i}),
    .q_o   (pins_al)
  );

  spi_reg_bank #(.BW(BW), .NREG(NREG), .AW(AW)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  spi_frame_ctrl #(.BW(BW), .DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise_i    (sck_rise),
    .fall_i    (sck_fall),
    .mosi_i    (pins_al[0]),
    .csn_i     (pins_al[1]),
    .rd_idx_o  (rd_idx),
    .rd_data_i (rd_data),
    .miso_o    (miso_o)
  );

endmodule

// File: tb/sim_spi_regread_slave.sv
`timescale 1ns/1ps
module sim_spi_regread_slave;
  localparam int HALF = 8;
  localparam logic [7:0] DEV = 8'hA5;

  function automatic logic [7:0] init_val(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  // {device, register, expected}
  localparam int NV = 7;
  localparam logic [23:0] VEC [NV] = '{
    {DEV,   8'h00, init_val(0)},
    {DEV,   8'h0F, init_val(15)},
    {DEV,   8'h07, init_val(7)},
    {DEV,   8'h0A, init_val(10)},
    {8'h5A, 8'h03, 8'h00},
    {DEV,   8'h20, 8'h00},
    {8'hA4, 8'h01, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, mosi = 1'b0, csn = 1'b1;
  logic miso;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spi_regread_slave u0 (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .mosi_i(mosi), .csn_i(csn),
    .miso_o(miso), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic write_reg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // glitch: 1 = spike in a low phase and dropout in a high phase
  task automatic run_frame(input logic [7:0] dev, input logic [7:0] ra, input bit glitch,
                           output logic [7:0] rd, output logic quiet, output logic tail);
    logic [23:0] tx;
    tx = {dev, ra, 8'h3C};
    rd = '0; quiet = 1'b1;
    csn = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int k = 23; k >= 0; k--) begin
      mosi = tx[k];
      if (glitch && k == 20) begin
        repeat (3) @(negedge clk); sclk = 1'b1;
        @(negedge clk); sclk = 1'b0;
        repeat (HALF - 4) @(negedge clk);
      end else begin
        repeat (HALF) @(negedge clk);
      end
      if (k >= 8) begin
        if (miso !== 1'b0) quiet = 1'b0;
      end else begin
        rd[k] = miso;
      end
      sclk = 1'b1;
      if (glitch && k == 19) begin
        repeat (3) @(negedge clk); sclk = 1'b0;
        @(negedge clk); sclk = 1'b1;
        repeat (HALF - 4) @(negedge clk);
      end else begin
        repeat (HALF) @(negedge clk);
      end
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    tail = miso;
    csn = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic quiet, tail;
    repeat (3) @(negedge clk);
    chk("R8 reset miso", {7'b0, miso}, 8'h00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 idle miso", {7'b0, miso}, 8'h00);

    for (int i = 0; i < 16; i++) write_reg(4'(i), init_val(i));

    for (int v = 0; v < NV; v++) begin
      run_frame(VEC[v][23:16], VEC[v][15:8], 1'b0, rd, quiet, tail);
      chk($sformatf("R1 R3 R4 R5 R6 R9 vec%0d readback", v), rd, VEC[v][7:0]);
      chk($sformatf("R8 vec%0d address phase quiet", v), {7'b0, quiet}, 8'h01);
      if (v == 0) chk("R8 after last bit", {7'b0, tail}, 8'h00);
    end

    // R2: glitches in both phases of the device-address byte
    run_frame(DEV, 8'h05, 1'b1, rd, quiet, tail);
    chk("R2 glitched frame readback", rd, init_val(5));
    chk("R2 glitched frame quiet", {7'b0, quiet}, 8'h01);

    // R7: abandon after five bits
    csn = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      mosi = k[0];
      repeat (HALF) @(negedge clk); sclk = 1'b1;
      repeat (HALF) @(negedge clk); sclk = 1'b0;
    end
    csn = 1'b1;
    repeat (2 * HALF) @(negedge clk);
    chk("R7 miso after abort", {7'b0, miso}, 8'h00);
    run_frame(DEV, 8'h0C, 1'b0, rd, quiet, tail);
    chk("R7 frame after abort", rd, init_val(12));

    // R9: write then read back
    write_reg(4'h3, 8'hE7);
    run_frame(DEV, 8'h03, 1'b0, rd, quiet, tail);
    chk("R9 rewritten register", rd, 8'hE7);
    write_reg(4'h9, 8'h81);
    run_frame(DEV, 8'h09, 1'b0, rd, quiet, tail);
    chk("R5 R9 edge bits", rd, 8'h81);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule